// File: doc/BRIEF.md
# Multi-channel PCM time-slot serial port

This block is the serial side of a four-channel PCM codec. One master bit clock times everything. Each channel has its own transmit frame-sync input. The first rising clock edge that sees a channel's sync high opens that channel's 8-bit slot. During the slot, the channel's byte is shifted out on one shared serial output, most significant bit first. Outside every slot the shared output is released. The release is modelled as an output-enable that goes low, with the data bit held at zero.

Receive works on the opposite clock edge. A companion generator derives receive syncs from the transmit syncs and the frame-separation offset. Each receive sync opens that channel's receive slot, and eight bits are taken from the shared serial input on consecutive falling edges. The assembled byte then appears on the channel's lane of the parallel output bus, together with a one-cycle valid strobe. The bit clock normally gives 256 or 512 periods per 8 kHz frame. Frame syncs of different channels are spaced by whole slots, so slots never overlap.

Top module: `pcm_slot_port`

## Requirements
- R1: While reset is held, and after it is released with no sync applied, `dx_oe` and `rx_valid` are low and `rx_byte` is all zeros.
- R2: A channel's transmit byte is taken from its lane of `tx_byte` (bits 8c+7..8c for channel c) at the rising edge that first sees that channel's `fs_tx` high. Later changes to `tx_byte` do not alter the byte being sent.
- R3: From the detecting rising edge onward, `dx_oe` is high for exactly 8 clock periods. `dx_data` carries bit 7 first and bit 0 last, one new bit after each rising edge.
- R4: Outside active transmit slots, `dx_oe` is low and `dx_data` is 0.
- R5: A sync held high for several clock periods opens only one slot. A channel starts no new slot until its sync has been low for at least one edge.
- R6: Slots of different channels can sit back to back with no idle bit between them. At any time at most one channel drives the shared output.
- R7: On the falling edge that first sees a channel's `fs_rx` high, `dr_in` is sampled as bit 7. The next seven falling edges sample bits 6 down to 0.
- R8: After the eighth sample, that channel's lane of `rx_byte` (bits 8c+7..8c) takes the assembled byte. At the same falling edge, `rx_valid[c]` goes high for exactly one clock period.
- R9: Values on `dr_in` outside a channel's receive slot are ignored. That channel's `rx_valid` stays low and its lane of `rx_byte` keeps its last value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fs_tx | input | 4 | Per-channel transmit frame syncs, edge triggered |
| tx_byte | input | 32 | Parallel transmit bytes, channel c at bits 8c+7..8c |
| dx_data | output | 1 | Shared serial transmit data |
| dx_oe | output | 1 | Output enable of the shared transmit line |
| fs_rx | input | 4 | Per-channel receive syncs, sampled on falling edge |
| dr_in | input | 1 | Shared serial receive data |
| rx_byte | output | 32 | Received bytes, channel c at bits 8c+7..8c |
| rx_valid | output | 4 | One-cycle strobe per channel when its byte is updated |

## Verification
The sweep runs twelve frames. Across them the order in which channels take slots is rotated, so a byte that leaves on the wrong lane or in the wrong slot shows up. Slot spacing alternates between back-to-back and one-slot gaps, which separates a correct slot end from an off-by-one enable. Sync widths of one to three clocks tell true edge detection apart from level sensing. `tx_byte` is scrambled on every cycle except the sync edge, which exposes any late sampling. The receive offset varies from zero to two clocks, and random noise on `dr_in` between slots must leave the captured bytes untouched.

// File: rtl/pcm_slot_pkg.sv
package pcm_slot_pkg;
   localparam int unsigned SLOT_BITS_DEF  = 8;
   localparam int unsigned NUM_CH_DEF     = 4;
   localparam int unsigned FRAME_CLKS_DEF = 256;

   function automatic int unsigned cnt_width(input int unsigned n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/pcm_tx_lane.sv
module pcm_tx_lane
   import pcm_slot_pkg::*;
#(
   parameter int unsigned SLOT_BITS = SLOT_BITS_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fs,
   input  logic [SLOT_BITS-1:0] byte_in,
   output logic                 oe,
   output logic                 bit_out
);
   localparam int unsigned CW = cnt_width(SLOT_BITS);
   localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

   logic                 fs_q;
   logic                 sync_edge;
   logic                 active;
   logic [CW-1:0]        cnt;
   logic [SLOT_BITS-1:0] sh;

   assign sync_edge = fs & ~fs_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q   <= 1'b0;
         active <= 1'b0;
         cnt    <= '0;
         sh     <= '0;
      end else begin
         fs_q <= fs;
         if (sync_edge) begin
            sh     <= byte_in;
            active <= 1'b1;
            cnt    <= '0;
         end else if (active) begin
            sh  <= {sh[SLOT_BITS-2:0], 1'b0};
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) begin
               active <= 1'b0;
            end
         end
      end
   end

   assign oe      = active;
   assign bit_out = active & sh[SLOT_BITS-1];

   // R2: the first bit on the line is the MSB present at the sync edge
   p_load_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_edge |=> (oe && bit_out == $past(byte_in[SLOT_BITS-1])));

   // R3: slot closes after its last bit
   p_slot_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (active && cnt == LAST && !sync_edge) |=> !oe);

   // R5: a held-high sync does not reopen a slot
   p_no_retrig_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fs && $past(fs)) |-> !sync_edge);
endmodule

// File: rtl/pcm_rx_lane.sv
module pcm_rx_lane
   import pcm_slot_pkg::*;
#(
   parameter int unsigned SLOT_BITS = SLOT_BITS_DEF
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fs,
   input  logic                 din,
   output logic [SLOT_BITS-1:0] byte_out,
   output logic                 valid
);
   localparam int unsigned CW = cnt_width(SLOT_BITS);
   localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

   logic                 fs_q;
   logic                 sync_edge;
   logic                 active;
   logic [CW-1:0]        cnt;
   logic [SLOT_BITS-1:0] sh;

   assign sync_edge = fs & ~fs_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fs_q     <= 1'b0;
         active   <= 1'b0;
         cnt      <= '0;
         sh       <= '0;
         byte_out <= '0;
         valid    <= 1'b0;
      end else begin
         fs_q  <= fs;
         valid <= 1'b0;
         if (sync_edge) begin
            sh     <= {{(SLOT_BITS-1){1'b0}}, din};
            cnt    <= CW'(1);
            active <= 1'b1;
         end else if (active) begin
            sh  <= {sh[SLOT_BITS-2:0], din};
            cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
            if (cnt == LAST) begin
               active   <= 1'b0;
               byte_out <= {sh[SLOT_BITS-2:0], din};
               valid    <= 1'b1;
            end
         end
      end
   end

   // R8: valid is a single-cycle strobe
   p_valid_pulse_r8: assert property (@(negedge clk) disable iff (!rst_n)
      valid |=> !valid);

   // R9: no slot open, no edge: nothing changes at the output
   p_ignore_idle_r9: assert property (@(negedge clk) disable iff (!rst_n)
      (!active && !sync_edge) |=> (!valid && $stable(byte_out)));
endmodule

// File: rtl/pcm_tx_merge.sv
module pcm_tx_merge
   import pcm_slot_pkg::*;
#(
   parameter int unsigned NUM_CH = NUM_CH_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] lane_oe,
   input  logic [NUM_CH-1:0] lane_bit,
   output logic              oe,
   output logic              data
);
   assign oe   = |lane_oe;
   assign data = |(lane_oe & lane_bit);

   // R6: never two channels on the shared line
   p_one_driver_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(lane_oe));

   // R4: released line carries zero
   p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !oe |-> !data);
endmodule

// File: rtl/pcm_slot_port.sv
module pcm_slot_port
   import pcm_slot_pkg::*;
#(
   parameter int unsigned NUM_CH     = NUM_CH_DEF,
   parameter int unsigned SLOT_BITS  = SLOT_BITS_DEF,
   parameter int unsigned FRAME_CLKS = FRAME_CLKS_DEF
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NUM_CH-1:0]           fs_tx,
   input  logic [NUM_CH*SLOT_BITS-1:0] tx_byte,
   output logic                        dx_data,
   output logic                        dx_oe,
   input  logic [NUM_CH-1:0]           fs_rx,
   input  logic                        dr_in,
   output logic [NUM_CH*SLOT_BITS-1:0] rx_byte,
   output logic [NUM_CH-1:0]           rx_valid
);
   localparam int unsigned SLOT_CLKS = NUM_CH * SLOT_BITS;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("pcm_slot_port: NUM_CH must be at least 1");
   end
   if (SLOT_BITS < 2) begin : g_bad_bits
      $error("pcm_slot_port: SLOT_BITS must be at least 2");
   end
   if (FRAME_CLKS < SLOT_CLKS) begin : g_bad_frame
      $error("pcm_slot_port: frame too short for all slots");
   end

   logic [NUM_CH-1:0] lane_oe;
   logic [NUM_CH-1:0] lane_bit;

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      pcm_tx_lane #(.SLOT_BITS(SLOT_BITS)) u_tx (
         .clk     (clk),
         .rst_n   (rst_n),
         .fs      (fs_tx[c]),
         .byte_in (tx_byte[c*SLOT_BITS +: SLOT_BITS]),
         .oe      (lane_oe[c]),
         .bit_out (lane_bit[c])
      );

      pcm_rx_lane #(.SLOT_BITS(SLOT_BITS)) u_rx (
         .clk      (clk),
         .rst_n    (rst_n),
         .fs       (fs_rx[c]),
         .din      (dr_in),
         .byte_out (rx_byte[c*SLOT_BITS +: SLOT_BITS]),
         .valid    (rx_valid[c])
      );
   end

   pcm_tx_merge #(.NUM_CH(NUM_CH)) u_merge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lane_oe  (lane_oe),
      .lane_bit (lane_bit),
      .oe       (dx_oe),
      .data     (dx_data)
   );

   // R1: nothing leaves the port during reset
   p_reset_quiet_r1: assert property (@(posedge clk)
      !rst_n |-> (!dx_oe && rx_valid == '0));
endmodule

// File: tb/pcm_slot_port_tb.sv
module pcm_slot_port_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NCH   = 4;
   localparam int SB    = 8;
   localparam int FLEN  = 70;
   localparam int NFRM  = 12;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NCH-1:0]    fs_tx = '0;
   logic [NCH*SB-1:0] tx_byte = '0;
   logic              dx_data, dx_oe;
   logic [NCH-1:0]    fs_rx = '0;
   logic              dr_in = 1'b0;
   logic [NCH*SB-1:0] rx_byte;
   logic [NCH-1:0]    rx_valid;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   int        s  [NCH];
   int        r  [NCH];
   int        w  [NCH];
   logic [7:0] tb [NCH];
   logic [7:0] rb [NCH];
   logic [7:0] last_rx [NCH];

   always #(CLK_PERIOD/2) clk = ~clk;

   pcm_slot_port #(.NUM_CH(NCH), .SLOT_BITS(SB), .FRAME_CLKS(256)) dut_i (
      .clk(clk), .rst_n(rst_n), .fs_tx(fs_tx), .tx_byte(tx_byte),
      .dx_data(dx_data), .dx_oe(dx_oe), .fs_rx(fs_rx), .dr_in(dr_in),
      .rx_byte(rx_byte), .rx_valid(rx_valid)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      for (int c = 0; c < NCH; c++) last_rx[c] = 8'h00;
      repeat (3) @(posedge clk);
      #1;
      // R1 during reset
      chk(dx_oe == 1'b0, "R1", "dx_oe in reset", 32'(dx_oe), 0);
      chk(rx_valid == '0, "R1", "rx_valid in reset", 32'(rx_valid), 0);
      chk(rx_byte == '0, "R1", "rx_byte in reset", rx_byte, 0);
      @(negedge clk); #1;
      rst_n = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      chk(dx_oe == 1'b0 && dx_data == 1'b0, "R1", "line idle after reset",
          {30'd0, dx_oe, dx_data}, 0);
      chk(rx_valid == '0, "R1", "rx_valid after reset", 32'(rx_valid), 0);

      for (int f = 0; f < NFRM; f++) begin
         for (int c = 0; c < NCH; c++) begin
            int k;
            k     = (c + f) % NCH;
            s[c]  = 2 + SB * k * (1 + (f % 2));
            r[c]  = s[c] + (f % 3);
            w[c]  = 1 + ((c + f) % 3);
            tb[c] = 8'((f * 37) + (c * 91) + 5) ^ ((f == 3) ? 8'hFF : 8'h00);
            rb[c] = 8'((f * 53) + (c * 29) + 170);
         end
         for (int n = 0; n < FLEN; n++) begin
            @(posedge clk); #1;
            // receive side (state after previous falling edge)
            for (int c = 0; c < NCH; c++) begin
               if (n == r[c] + SB) begin
                  chk(rx_valid[c] == 1'b1, "R8", "rx_valid strobe",
                      32'(rx_valid[c]), 1);
                  chk(rx_byte[c*SB +: SB] == rb[c], "R7", "received byte",
                      32'(rx_byte[c*SB +: SB]), 32'(rb[c]));
                  last_rx[c] = rb[c];
               end else begin
                  chk(rx_valid[c] == 1'b0, "R8", "rx_valid outside strobe",
                      32'(rx_valid[c]), 0);
                  chk(rx_byte[c*SB +: SB] == last_rx[c], "R9", "rx_byte held",
                      32'(rx_byte[c*SB +: SB]), 32'(last_rx[c]));
               end
            end
            begin
               logic d;
               d = 1'($urandom % 2);
               for (int c = 0; c < NCH; c++) begin
                  fs_rx[c] = (n >= r[c]) && (n < r[c] + w[c]);
                  if (n >= r[c] && n < r[c] + SB) d = rb[c][SB-1-(n-r[c])];
               end
               dr_in = d;
            end
            @(negedge clk); #1;
            // transmit side (state after this rising edge)
            begin
               logic oe_e, d_e;
               oe_e = 1'b0;
               d_e  = 1'b0;
               for (int c = 0; c < NCH; c++) begin
                  if (n >= s[c] && n < s[c] + SB) begin
                     oe_e = 1'b1;
                     d_e  = tb[c][SB-1-(n-s[c])];
                  end
               end
               chk(dx_oe == oe_e, oe_e ? "R3" : "R4", "dx_oe",
                   32'(dx_oe), 32'(oe_e));
               chk(dx_data == d_e, oe_e ? "R2" : "R4", "dx_data",
                   32'(dx_data), 32'(d_e));
            end
            for (int c = 0; c < NCH; c++) begin
               // R5: wide syncs; R2: tx_byte is scrambled except at the edge
               fs_tx[c] = (n + 1 >= s[c]) && (n + 1 < s[c] + w[c]);
               tx_byte[c*SB +: SB] = (n + 1 == s[c]) ? tb[c]
                                     : (~tb[c] ^ 8'(n));
            end
         end
      end
      finish_run();
   end
endmodule